// File: doc/BRIEF.md
# Revolution Ripple Clock Generator

This block holds an up/down position count and moves it by one LSB for every step request. Each time the count passes through its major carry, it raises a revolution marker. The major carry is the wrap from all ones to all zeros when counting up, or from all zeros to all ones when counting down. A downstream revolution or pitch counter uses this marker as its clock. The block also gives a registered direction output and a one-cycle busy pulse for each applied step.

The marker has a guaranteed minimum high time, given in clock cycles. It normally drops on a busy pulse, the first one after that minimum has passed. If the direction flips while the marker is high, the marker stays high until the direction has been steady across a set number of consecutive steps (two by default). The output inhibit input has no influence on the marker or on any other output.

Top module: `rrc_ripple_gen`

## Requirements
- R1: While reset is asserted, `count_o` is 0, `busy_o` is 0, `ripple_o` is 0 and `dir_o` is 1.
- R2: A step request sampled high at clock edge k changes `count_o` at edge k+1. The count goes up by 1 when `dir_in` was 1 at edge k and down by 1 when it was 0, modulo 2^POS_W.
- R3: `busy_o` is high in exactly the cycles in which `count_o` shows a newly applied step.
- R4: `ripple_o` rises in the same cycle as a count change from all ones to 0, or from 0 to all ones, and at no other time.
- R5: `dir_o` equals `dir_in` as sampled at the previous clock edge, with 1 meaning up. The direction reaches `dir_o` one cycle before the step that uses it shows on `count_o`.
- R6: Once risen, `ripple_o` stays high for at least MIN_HIGH_CYC cycles.
- R7: If the direction has not changed during the pulse, `ripple_o` falls in the cycle of the first `busy_o` pulse after it has been high for MIN_HIGH_CYC cycles. It only ever falls together with a `busy_o` pulse.
- R8: When the minimum width has passed but no step arrives, `ripple_o` stays high.
- R9: If `dir_o` changes while `ripple_o` is high, `ripple_o` falls only on a step that completes STABLE_STEPS consecutive steps applied with no change of `dir_o` in between. Toggles of `dir_in` with no step between them restart that count.
- R10: `inhibit_in` has no effect on `ripple_o`, `count_o`, `busy_o` or `dir_o`.
- R11: A new wrap while `ripple_o` is high keeps it high and starts a fresh pulse. That means a new minimum-width window, and any earlier direction hold is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_in | input | 1 | Request to move the count by one LSB |
| dir_in | input | 1 | Requested direction, 1 = up |
| inhibit_in | input | 1 | Output inhibit; ignored by this block |
| count_o | output | POS_W | Position count |
| busy_o | output | 1 | One cycle high for each applied step |
| ripple_o | output | 1 | Revolution marker |
| dir_o | output | 1 | Registered direction, 1 = up |

## Verification
Slow upward and downward runs through the carry separate a correct wrap decode from an off-by-one. They also show whether the marker waits for a step once the width timer has expired, or drops on the timer alone. A run that toggles direction with no steps, then steps twice, separates the stability hold from a plain single-step clear. A down wrap followed at once by an up wrap shows that the pulse restarts. A long random walk with random inhibit is compared on every clock against a behavioural model, which catches any ordering error between direction, count and marker.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

   // Step event handed from the position counter to the pulse control
   typedef struct packed {
      logic fire;   // a step is applied at this edge
      logic wrap;   // that step crosses the major carry
   } rrc_step_t;

   // Bits needed to hold the values 0..limit
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/rrc_pos_counter.sv
module rrc_pos_counter
   import rrc_pkg::*;
#(
   parameter int unsigned POS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dir_now,
   output logic [POS_W-1:0] count_o,
   output logic             busy_o,
   output rrc_step_t        evt_o
);

   localparam logic [POS_W-1:0] TOP_VAL = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] ONE_VAL = POS_W'(1);

   logic step_q;
   logic at_carry;

   // The step waits one cycle so that the direction is registered first
   always_comb begin
      at_carry   = dir_now ? (count_o == TOP_VAL) : (count_o == '0);
      evt_o.fire = step_q;
      evt_o.wrap = step_q & at_carry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= 1'b0;
         busy_o  <= 1'b0;
         count_o <= '0;
      end else begin
         step_q <= step_in;
         busy_o <= step_q;
         if (step_q) begin
            count_o <= dir_now ? (count_o + ONE_VAL) : (count_o - ONE_VAL);
         end
      end
   end

endmodule

// File: rtl/rrc_dir_tracker.sv
module rrc_dir_tracker
   import rrc_pkg::*;
#(
   parameter int unsigned STABLE_STEPS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_in,
   input  logic fire,
   output logic dir_o,
   output logic chg_o,
   output logic stable_o
);

   localparam int unsigned   SW      = cnt_bits(STABLE_STEPS);
   localparam logic [SW-1:0] RUN_LIM = SW'(STABLE_STEPS);
   localparam logic [SW-1:0] RUN_ONE = SW'(1);

   logic          dir_prev;
   logic [SW-1:0] run_q;
   logic [SW-1:0] run_d;

   // Count the steps applied since dir_o last changed, saturating at the limit
   always_comb begin
      chg_o = dir_o ^ dir_prev;
      if (chg_o) begin
         run_d = fire ? RUN_ONE : '0;
      end else if (fire && (run_q < RUN_LIM)) begin
         run_d = run_q + RUN_ONE;
      end else begin
         run_d = run_q;
      end
      stable_o = (run_d >= RUN_LIM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o    <= 1'b1;
         dir_prev <= 1'b1;
         run_q    <= '0;
      end else begin
         dir_o    <= dir_in;
         dir_prev <= dir_o;
         run_q    <= run_d;
      end
   end

endmodule

// File: rtl/rrc_pulse_ctrl.sv
module rrc_pulse_ctrl
   import rrc_pkg::*;
#(
   parameter int unsigned MIN_HIGH_CYC = 30
) (
   input  logic      clk,
   input  logic      rst_n,
   input  rrc_step_t evt_i,
   input  logic      chg_i,
   input  logic      stable_i,
   output logic      ripple_o
);

   logic timer_ok;
   logic dirty_q;
   logic dirty_eff;
   logic set_p;
   logic clr_p;

   always_comb begin
      dirty_eff = dirty_q | (chg_i & ripple_o);
      set_p     = evt_i.wrap;
      clr_p     = ripple_o & evt_i.fire & timer_ok & ~set_p &
                  (~dirty_eff | stable_i);
   end

   generate
      if (MIN_HIGH_CYC <= 1) begin : g_no_timer
         // The clear needs ripple_o high already, so one cycle is given anyway
         assign timer_ok = 1'b1;
      end else begin : g_timer
         localparam int unsigned   TW   = cnt_bits(MIN_HIGH_CYC);
         localparam logic [TW-1:0] TLIM = TW'(MIN_HIGH_CYC);
         localparam logic [TW-1:0] TONE = TW'(1);
         logic [TW-1:0] high_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               high_q <= '0;
            end else if (set_p) begin
               high_q <= TONE;
            end else if (clr_p) begin
               high_q <= '0;
            end else if (ripple_o && (high_q < TLIM)) begin
               high_q <= high_q + TONE;
            end
         end

         assign timer_ok = (high_q >= TLIM);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ripple_o <= 1'b0;
         dirty_q  <= 1'b0;
      end else if (set_p) begin
         ripple_o <= 1'b1;
         dirty_q  <= 1'b0;
      end else if (clr_p) begin
         ripple_o <= 1'b0;
         dirty_q  <= 1'b0;
      end else begin
         dirty_q  <= dirty_eff;
      end
   end

endmodule

// File: rtl/rrc_ripple_gen.sv
module rrc_ripple_gen
   import rrc_pkg::*;
#(
   parameter int unsigned POS_W        = 16,
   parameter int unsigned MIN_HIGH_CYC = 30,
   parameter int unsigned STABLE_STEPS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dir_in,
   input  logic             inhibit_in,
   output logic [POS_W-1:0] count_o,
   output logic             busy_o,
   output logic             ripple_o,
   output logic             dir_o
);

   generate
      if (POS_W < 2) begin : g_bad_pos_w
         $error("rrc_ripple_gen: POS_W must be 2 or more");
      end
      if (MIN_HIGH_CYC < 1) begin : g_bad_min_high
         $error("rrc_ripple_gen: MIN_HIGH_CYC must be 1 or more");
      end
      if (STABLE_STEPS < 1) begin : g_bad_stable
         $error("rrc_ripple_gen: STABLE_STEPS must be 1 or more");
      end
   endgenerate

   // The marker and the count do not depend on the output inhibit
   logic unused_inhibit;
   assign unused_inhibit = inhibit_in;

   rrc_step_t evt;
   logic      dir_chg;
   logic      dir_stable;

   rrc_dir_tracker #(
      .STABLE_STEPS (STABLE_STEPS)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_in   (dir_in),
      .fire     (evt.fire),
      .dir_o    (dir_o),
      .chg_o    (dir_chg),
      .stable_o (dir_stable)
   );

   rrc_pos_counter #(
      .POS_W (POS_W)
   ) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_in (step_in),
      .dir_now (dir_o),
      .count_o (count_o),
      .busy_o  (busy_o),
      .evt_o   (evt)
   );

   rrc_pulse_ctrl #(
      .MIN_HIGH_CYC (MIN_HIGH_CYC)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt),
      .chg_i    (dir_chg),
      .stable_i (dir_stable),
      .ripple_o (ripple_o)
   );

endmodule

// File: rtl/rrc_ripple_gen_chk.sv
module rrc_ripple_gen_chk #(
   parameter int unsigned POS_W        = 16,
   parameter int unsigned MIN_HIGH_CYC = 30
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dir_in,
   input logic [POS_W-1:0] count_o,
   input logic             busy_o,
   input logic             ripple_o,
   input logic             dir_o
);

   localparam int unsigned   HW   = (MIN_HIGH_CYC < 2) ? 1 : $clog2(MIN_HIGH_CYC + 1);
   localparam logic [HW-1:0] HLIM = HW'(MIN_HIGH_CYC);

   logic [HW-1:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_run <= '0;
      end else if (ripple_o) begin
         if (high_run < HLIM) high_run <= high_run + HW'(1);
      end else begin
         high_run <= '0;
      end
   end

   // R5: direction output is the input delayed by one edge
   p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dir_o == $past(dir_in)));

   // R4: an upward wrap raises the marker in the same cycle
   p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && busy_o && (count_o == '0) && ($past(count_o) == '1)) |-> ripple_o);

   // R4: a downward wrap raises the marker in the same cycle
   p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && busy_o && (count_o == '1) && ($past(count_o) == '0)) |-> ripple_o);

   // R4: the marker rises only together with an applied step
   p_rise_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ripple_o) |-> busy_o);

   // R7: the marker falls only together with a busy pulse
   p_fall_on_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ripple_o) |-> busy_o);

   // R6: the marker was high for the minimum width before falling
   p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ripple_o) |-> (high_run >= HLIM));

endmodule

bind rrc_ripple_gen rrc_ripple_gen_chk #(
   .POS_W        (POS_W),
   .MIN_HIGH_CYC (MIN_HIGH_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dir_in   (dir_in),
   .count_o  (count_o),
   .busy_o   (busy_o),
   .ripple_o (ripple_o),
   .dir_o    (dir_o)
);

// File: tb/rrc_ripple_gen_test.sv
module rrc_ripple_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int MINC       = 5;
   localparam int STAB       = 2;
   localparam int MAXC       = (1 << W) - 1;

   logic         clk        = 1'b0;
   logic         rst_n      = 1'b0;
   logic         step_in    = 1'b0;
   logic         dir_in     = 1'b1;
   logic         inhibit_in = 1'b0;
   logic [W-1:0] count_o;
   logic         busy_o;
   logic         ripple_o;
   logic         dir_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   rrc_ripple_gen #(
      .POS_W        (W),
      .MIN_HIGH_CYC (MINC),
      .STABLE_STEPS (STAB)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_in    (step_in),
      .dir_in     (dir_in),
      .inhibit_in (inhibit_in),
      .count_o    (count_o),
      .busy_o     (busy_o),
      .ripple_o   (ripple_o),
      .dir_o      (dir_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_pipe[$];
   int m_cnt, m_busy, m_rip, m_dir, m_high, m_same;
   bit m_dirty, m_chg;
   int ev, same_n;
   bit fire, pd, wrap, dirty_e;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pipe.delete();
         m_pipe.push_back(0);
         m_cnt = 0; m_busy = 0; m_rip = 0; m_dir = 1;
         m_high = 0; m_same = 0; m_dirty = 0; m_chg = 0;
      end else begin
         ev   = m_pipe.pop_front();
         fire = ev[0];
         pd   = ev[1];
         wrap = fire && ((pd && m_cnt == MAXC) || (!pd && m_cnt == 0));
         if (m_chg) same_n = fire ? 1 : 0;
         else if (fire) same_n = (m_same < STAB) ? m_same + 1 : m_same;
         else same_n = m_same;
         dirty_e = m_dirty || (m_chg && m_rip == 1);
         if (wrap) begin
            m_rip = 1; m_high = 1; m_dirty = 0;
         end else if (m_rip == 1 && fire && m_high >= MINC && (!dirty_e || same_n >= STAB)) begin
            m_rip = 0; m_high = 0; m_dirty = 0;
         end else begin
            m_dirty = dirty_e;
            if (m_rip == 1 && m_high < MINC) m_high++;
         end
         m_same = same_n;
         if (fire) m_cnt = pd ? ((m_cnt + 1) & MAXC) : ((m_cnt + MAXC) & MAXC);
         m_busy = fire ? 1 : 0;
         m_chg  = (int'(dir_in) != m_dir);
         m_dir  = int'(dir_in);
         m_pipe.push_back((int'(dir_in) << 1) | int'(step_in));
      end
   end

   // ---------------- per-cycle comparison ----------------
   int hi_len = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 count vs model", int'(count_o), m_cnt);
         check("R3 busy vs model", int'(busy_o), m_busy);
         check("R5 dir vs model", int'(dir_o), m_dir);
         check("R9 ripple vs model", int'(ripple_o), m_rip);
         if (ripple_o) hi_len++;
         else begin
            if (hi_len > 0) check("R6 measured high width >= min", int'(hi_len >= MINC), 1);
            hi_len = 0;
         end
      end else begin
         hi_len = 0;
      end
   end

   task automatic do_step(input logic d, input int gap);
      dir_in  = d;
      step_in = 1'b1;
      @(negedge clk);
      step_in = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic check_reset_state();
      check("R1 count in reset", int'(count_o), 0);
      check("R1 busy in reset", int'(busy_o), 0);
      check("R1 ripple in reset", int'(ripple_o), 0);
      check("R1 dir in reset", int'(dir_o), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      @(negedge clk);

      // R5: direction registered one edge later
      dir_in = 1'b0;
      @(negedge clk);
      check("R5 dir_o follows 0", int'(dir_o), 0);
      dir_in = 1'b1;
      @(negedge clk);
      check("R5 dir_o follows 1", int'(dir_o), 1);

      // R2/R4: slow upward run to the carry
      for (int i = 0; i < 15; i++) do_step(1'b1, 3);
      check("R2 count after 15 up steps", int'(count_o), 15);
      check("R4 no marker before carry", int'(ripple_o), 0);
      do_step(1'b1, 1);
      check("R4 count wrapped up", int'(count_o), 0);
      check("R4 marker on up wrap", int'(ripple_o), 1);
      check("R3 busy with wrap step", int'(busy_o), 1);
      @(negedge clk);
      check("R3 busy single cycle", int'(busy_o), 0);
      repeat (9) @(negedge clk);
      check("R8 marker held without step", int'(ripple_o), 1);
      do_step(1'b1, 1);
      check("R7 marker cleared on step", int'(ripple_o), 0);
      check("R2 count after clear step", int'(count_o), 1);

      // R4: downward wrap
      do_step(1'b0, 3);
      do_step(1'b0, 1);
      check("R4 count wrapped down", int'(count_o), 15);
      check("R4 marker on down wrap", int'(ripple_o), 1);

      // R9: direction toggles while high, then two stable steps
      repeat (8) @(negedge clk);
      dir_in = 1'b1;
      @(negedge clk);
      dir_in = 1'b0;
      @(negedge clk);
      do_step(1'b0, 1);
      check("R9 held after one stable step", int'(ripple_o), 1);
      check("R9 count after first step", int'(count_o), 14);
      do_step(1'b0, 1);
      check("R9 cleared after two stable steps", int'(ripple_o), 0);
      check("R9 count after second step", int'(count_o), 13);

      // R11: back-to-back wraps restart the pulse
      for (int i = 0; i < 13; i++) do_step(1'b0, 2);
      check("R2 count back at zero", int'(count_o), 0);
      do_step(1'b0, 1);
      check("R11 first wrap", int'(ripple_o), 1);
      do_step(1'b1, 1);
      check("R11 count after reverse wrap", int'(count_o), 0);
      check("R11 marker kept high", int'(ripple_o), 1);
      do_step(1'b1, 1);
      check("R11 timer restarted keeps marker", int'(ripple_o), 1);
      repeat (6) @(negedge clk);
      do_step(1'b1, 1);
      check("R7 clear after restarted pulse", int'(ripple_o), 0);
      check("R2 count two", int'(count_o), 2);

      // R10: inhibit held through a wrap and a clear
      inhibit_in = 1'b1;
      for (int i = 0; i < 13; i++) do_step(1'b1, 2);
      do_step(1'b1, 1);
      check("R10 marker rises under inhibit", int'(ripple_o), 1);
      check("R10 count wraps under inhibit", int'(count_o), 0);
      repeat (6) @(negedge clk);
      do_step(1'b1, 1);
      check("R10 marker clears under inhibit", int'(ripple_o), 0);
      inhibit_in = 1'b0;

      // random walk with random inhibit, checked against the model
      for (int i = 0; i < 3000; i++) begin
         step_in    = (($urandom % 3) == 0);
         if (($urandom % 4) == 0) dir_in = ~dir_in;
         inhibit_in = $urandom % 2;
         @(negedge clk);
      end
      step_in = 1'b0;

      // reset in the middle of operation
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule